// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that sits in ordinary memory. Pages are 4 KB, so the low 12 bits of the address are the page offset and pass straight through. The upper 20 bits are split into two 10-bit indices, one for each table level. Every table holds 1024 entries of 4 bytes, so one table fills exactly one page.

A requester offers an address together with a write flag. The walker then reads the top-level entry, and from it the leaf entry, over a simple memory read port. It returns the physical address and the leaf's writable flag. When an entry is not present, or when a write targets a read-only page, it returns a fault instead. A base register names the page that holds the top-level table. Software rewrites it on a context switch. A walk that is already running keeps the base it started with.

Only one walk runs at a time. The walker drops its ready output from acceptance until the result has been delivered. The memory behind the read port may stall a request and may return the data any number of cycles later.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready is 1, and rsp_valid and mem_req_valid are 0.
- R2: The first read of a walk goes to {base[31:12], va[31:22], 2'b00}, where base is the table base value in force when the request was accepted.
- R3: When the top-level entry has bit 0 (present) set, the second read goes to {entry[31:12], va[21:12], 2'b00}. Bit 1 of a top-level entry has no effect.
- R4: When the leaf entry has bit 0 set, and it either has bit 1 (writable) set or the request is a read, the walker raises rsp_valid for exactly one cycle. It then gives rsp_fault=0, rsp_paddr={leaf[31:12], va[11:0]} and rsp_writable equal to leaf bit 1.
- R5: A top-level entry with bit 0 clear ends the walk after one read: rsp_fault=1, rsp_fault_lvl=0, rsp_paddr=0 and rsp_writable=0.
- R6: A leaf entry with bit 0 clear ends the walk after two reads: rsp_fault=1, rsp_fault_lvl=1, rsp_paddr=0 and rsp_writable=0.
- R7: A write request (req_write=1) whose leaf entry is present but has bit 1 clear faults with rsp_fault_lvl=1. A read of the same page succeeds.
- R8: req_ready is 0 from the cycle after a request is accepted up to and including the cycle that carries rsp_valid. No memory read is issued while req_ready is 1.
- R9: A write of the table base register takes effect for walks accepted after it, even when it lands during a walk. The low 12 bits of the value written are ignored.
- R10: A memory read that is held off by mem_req_ready=0 stays valid with an unchanged address until it is accepted. Each level issues exactly one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Load the table base register |
| root_wdata | input | 32 | New table base; bits 11:0 ignored |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Physical address of the table entry |
| mem_resp_valid | input | 1 | Read data returned |
| mem_resp_data | input | 32 | Table entry read |
| rsp_valid | output | 1 | Result pulse, one cycle |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_lvl | output | 1 | Faulting level: 0 top, 1 leaf |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_writable | output | 1 | Leaf page permits writes |

## Verification
The assertions assume that the memory returns exactly one response for each accepted read, never in the same cycle as the acceptance, and that req_valid is raised only while req_ready is high. The bench's memory model stores each accepted read and answers it after a programmable delay of at least one cycle. Its driver waits for req_ready before it raises req_valid and holds it for a single accepting edge. Backpressure on mem_req_ready is toggled on for some walks so that a held request is exercised. Base register writes come either while the walker is idle or one edge after acceptance, never on the accepting edge itself.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

   typedef enum logic [2:0] {
      WS_IDLE    = 3'd0,
      WS_RD_TOP  = 3'd1,
      WS_RD_LEAF = 3'd2,
      WS_DONE    = 3'd3,
      WS_FAULT   = 3'd4
   } walk_st_e;

   localparam int unsigned NUM_LEVELS = 2;

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PA_W      = 32,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned LVL_BITS  = 10
) (
   input  logic [PA_W-PAGE_BITS-1:0] table_frame,
   input  logic [VA_W-1:0]           vaddr,
   input  logic                      leaf_sel,
   output logic [PA_W-1:0]           entry_addr
);
   import pgwalk_pkg::*;

   localparam int unsigned ENT_LG = PAGE_BITS - LVL_BITS;

   logic [LVL_BITS-1:0] idx [NUM_LEVELS];

   for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_idx
      assign idx[l] = vaddr[PAGE_BITS + l*LVL_BITS +: LVL_BITS];
   end

   wire unused_offset = ^vaddr[PAGE_BITS-1:0];

   always_comb begin
      entry_addr = {table_frame, (leaf_sel ? idx[0] : idx[NUM_LEVELS-1]),
                    {ENT_LG{1'b0}}};
   end

endmodule

// File: rtl/pgwalk_pte_chk.sv
module pgwalk_pte_chk #(
   parameter int unsigned PA_W       = 32,
   parameter int unsigned PAGE_BITS  = 12,
   parameter int unsigned V_BIT      = 0,
   parameter int unsigned W_BIT      = 1,
   parameter bit          ENFORCE_WR = 1'b1
) (
   input  logic [PA_W-1:0]           pte,
   input  logic                      is_leaf,
   input  logic                      is_write,
   output logic [PA_W-PAGE_BITS-1:0] frame,
   output logic                      wr_ok,
   output logic                      fault
);
   logic present;

   assign present = pte[V_BIT];
   assign wr_ok   = pte[W_BIT];
   assign frame   = pte[PA_W-1:PAGE_BITS];

   wire unused_low = ^pte[PAGE_BITS-1:0];

   if (ENFORCE_WR) begin : g_perm
      assign fault = !present || (is_leaf && is_write && !wr_ok);
   end else begin : g_noperm
      wire unused_perm = is_leaf ^ is_write;
      assign fault = !present;
   end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PA_W       = 32,
   parameter int unsigned PAGE_BITS  = 12,
   parameter int unsigned LVL_BITS   = 10,
   parameter int unsigned V_BIT      = 0,
   parameter int unsigned W_BIT      = 1,
   parameter bit          ENFORCE_WR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            root_we,
   input  logic [PA_W-1:0] root_wdata,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic            req_write,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_req_addr,
   input  logic            mem_resp_valid,
   input  logic [PA_W-1:0] mem_resp_data,
   output logic            rsp_valid,
   output logic            rsp_fault,
   output logic            rsp_fault_lvl,
   output logic [PA_W-1:0] rsp_paddr,
   output logic            rsp_writable
);
   import pgwalk_pkg::*;

   localparam int unsigned FRAME_W = PA_W - PAGE_BITS;

   if (VA_W != PAGE_BITS + NUM_LEVELS*LVL_BITS) begin : g_bad_split
      $error("virtual address width must equal offset plus all index fields");
   end
   if (PAGE_BITS <= LVL_BITS) begin : g_bad_entry
      $error("a table must fit in one page with entries of at least two bytes");
   end
   if (V_BIT >= PAGE_BITS || W_BIT >= PAGE_BITS || V_BIT == W_BIT) begin : g_bad_flags
      $error("flag bits must be distinct and below the frame field");
   end

   walk_st_e           st_q;
   logic               issued_q;
   logic [VA_W-1:0]    va_q;
   logic               wr_q;
   logic [FRAME_W-1:0] base_q;
   logic [FRAME_W-1:0] tbl_q;
   logic [FRAME_W-1:0] pa_frame_q;
   logic               wr_ok_q;
   logic               flt_lvl_q;

   logic               in_read;
   logic               is_leaf;
   logic               resp_take;
   logic [FRAME_W-1:0] chk_frame;
   logic               chk_wr_ok;
   logic               chk_fault;

   wire unused_base_low = ^root_wdata[PAGE_BITS-1:0];

   assign in_read   = (st_q == WS_RD_TOP) || (st_q == WS_RD_LEAF);
   assign is_leaf   = (st_q == WS_RD_LEAF);
   assign resp_take = in_read && issued_q && mem_resp_valid;

   pgwalk_addr #(
      .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .LVL_BITS(LVL_BITS)
   ) u_addr (
      .table_frame(tbl_q),
      .vaddr      (va_q),
      .leaf_sel   (is_leaf),
      .entry_addr (mem_req_addr)
   );

   pgwalk_pte_chk #(
      .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .V_BIT(V_BIT), .W_BIT(W_BIT),
      .ENFORCE_WR(ENFORCE_WR)
   ) u_chk (
      .pte     (mem_resp_data),
      .is_leaf (is_leaf),
      .is_write(wr_q),
      .frame   (chk_frame),
      .wr_ok   (chk_wr_ok),
      .fault   (chk_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (root_we) begin
         base_q <= root_wdata[PA_W-1:PAGE_BITS];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= WS_IDLE;
         issued_q   <= 1'b0;
         va_q       <= '0;
         wr_q       <= 1'b0;
         tbl_q      <= '0;
         pa_frame_q <= '0;
         wr_ok_q    <= 1'b0;
         flt_lvl_q  <= 1'b0;
      end else begin
         unique case (st_q)
            WS_IDLE: begin
               if (req_valid) begin
                  va_q     <= req_vaddr;
                  wr_q     <= req_write;
                  tbl_q    <= base_q;
                  issued_q <= 1'b0;
                  st_q     <= WS_RD_TOP;
               end
            end
            WS_RD_TOP, WS_RD_LEAF: begin
               if (mem_req_valid && mem_req_ready) begin
                  issued_q <= 1'b1;
               end
               if (resp_take) begin
                  issued_q <= 1'b0;
                  if (chk_fault) begin
                     flt_lvl_q <= is_leaf;
                     st_q      <= WS_FAULT;
                  end else if (!is_leaf) begin
                     tbl_q <= chk_frame;
                     st_q  <= WS_RD_LEAF;
                  end else begin
                     pa_frame_q <= chk_frame;
                     wr_ok_q    <= chk_wr_ok;
                     st_q       <= WS_DONE;
                  end
               end
            end
            WS_DONE, WS_FAULT: st_q <= WS_IDLE;
            default:           st_q <= WS_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == WS_IDLE);
   assign mem_req_valid = in_read && !issued_q;
   assign rsp_valid     = (st_q == WS_DONE) || (st_q == WS_FAULT);
   assign rsp_fault     = (st_q == WS_FAULT);
   assign rsp_fault_lvl = (st_q == WS_FAULT) && flt_lvl_q;
   assign rsp_paddr     = (st_q == WS_DONE) ? {pa_frame_q, va_q[PAGE_BITS-1:0]} : '0;
   assign rsp_writable  = (st_q == WS_DONE) && wr_ok_q;

   // a stalled read must keep its request and address
   assert_hold_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // the result is a single-cycle pulse followed by an idle walker
   assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready);

   // acceptance closes the request port
   assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // no memory traffic while the request port is open
   assert_no_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // a read accepted this cycle is not issued again next cycle
   assert_one_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);

   // a fault carries neither an address nor write permission
   assert_fault_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_paddr == '0 && !rsp_writable);

endmodule

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;

   typedef struct {
      logic        flt;
      logic        lvl;
      logic [31:0] pa;
      logic        wr;
      string       tag;
   } exp_t;

   typedef struct {
      logic [31:0] addr;
      string       tag;
   } rd_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        root_we = 1'b0;
   logic [31:0] root_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_resp_valid = 1'b0;
   logic [31:0] mem_resp_data = '0;
   logic        rsp_valid;
   logic        rsp_fault;
   logic        rsp_fault_lvl;
   logic [31:0] rsp_paddr;
   logic        rsp_writable;

   int checks = 0;
   int errors = 0;
   int seen   = 0;
   int lat    = 0;
   bit stall  = 1'b0;
   bit rdy_q  = 1'b1;

   exp_t exp_q[$];
   rd_t  rd_q[$];
   logic [31:0] pmem [logic [31:0]];

   logic        pend = 1'b0;
   logic [31:0] pend_addr = '0;
   int          pend_wait = 0;

   always #4 clk = ~clk;

   pgwalk_top u0 (
      .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
      .rsp_paddr(rsp_paddr), .rsp_writable(rsp_writable)
   );

   assign mem_req_ready = rdy_q;

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rdmem(input logic [31:0] a);
      return pmem.exists(a) ? pmem[a] : 32'h0;
   endfunction

   // behavioural memory with backpressure and delay
   always @(posedge clk) begin
      rdy_q          <= stall ? ~rdy_q : 1'b1;
      mem_resp_valid <= 1'b0;
      if (pend) begin
         if (pend_wait == 0) begin
            mem_resp_valid <= 1'b1;
            mem_resp_data  <= rdmem(pend_addr);
            pend           <= 1'b0;
         end else begin
            pend_wait <= pend_wait - 1;
         end
      end else if (rst_n && mem_req_valid && mem_req_ready) begin
         pend      <= 1'b1;
         pend_addr <= mem_req_addr;
         pend_wait <= lat;
         if (rd_q.size() == 0) begin
            chk(1'b0, "R10 unexpected extra read", mem_req_addr, 32'h0);
         end else begin
            rd_t r;
            r = rd_q.pop_front();
            chk(mem_req_addr == r.addr, r.tag, mem_req_addr, r.addr);
         end
      end
   end

   // monitor: compare results against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4 unexpected response", rsp_paddr, 32'h0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rsp_fault == e.flt, {e.tag, " fault"}, 32'(rsp_fault), 32'(e.flt));
            chk(rsp_fault_lvl == e.lvl, {e.tag, " level"}, 32'(rsp_fault_lvl), 32'(e.lvl));
            chk(rsp_paddr == e.pa, {e.tag, " paddr"}, rsp_paddr, e.pa);
            chk(rsp_writable == e.wr, {e.tag, " writable"}, 32'(rsp_writable), 32'(e.wr));
         end
         seen++;
      end
   end

   task automatic set_root(input logic [31:0] v);
      @(negedge clk);
      root_we    = 1'b1;
      root_wdata = v;
      @(negedge clk);
      root_we    = 1'b0;
   endtask

   task automatic walk(input logic [31:0] va, input bit wr, input bit flt,
                       input bit lvl, input logic [31:0] pa, input bit pw,
                       input logic [31:0] a1, input logic [31:0] a2, input int nrd,
                       input bit mid, input logic [31:0] mid_root, input string tag);
      exp_t e;
      rd_t  r;
      int   target;
      e.flt = flt; e.lvl = lvl; e.pa = pa; e.wr = pw; e.tag = tag;
      exp_q.push_back(e);
      r.addr = a1; r.tag = {tag, " first read R2"};
      rd_q.push_back(r);
      if (nrd > 1) begin
         r.addr = a2; r.tag = {tag, " second read R3"};
         rd_q.push_back(r);
      end
      target = seen + 1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      if (mid) begin
         root_we    = 1'b1;
         root_wdata = mid_root;
      end
      for (int n = 0; n < 200 && seen < target; n++) begin
         chk(!req_ready, {tag, " R8 ready low in walk"}, 32'(req_ready), 32'h0);
         @(negedge clk);
         root_we = 1'b0;
      end
      chk(rd_q.size() == 0, {tag, " R10 reads outstanding"}, rd_q.size(), 32'h0);
      rd_q.delete();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // tables for base A = 0x00100000
      pmem[32'h0010_0004] = 32'h0020_0001;
      pmem[32'h0020_000C] = 32'h0ABC_D003;
      pmem[32'h0020_0014] = 32'h0077_7001;
      pmem[32'h0010_0FFC] = 32'h0050_0001;
      pmem[32'h0050_0FFC] = 32'hFFFF_F003;
      // tables for base B = 0x00300000
      pmem[32'h0030_0004] = 32'h0040_0003;
      pmem[32'h0040_000C] = 32'h0123_4003;

      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1, "R1 ready in reset", 32'(req_ready), 32'h1);
      chk(rsp_valid === 1'b0, "R1 rsp idle in reset", 32'(rsp_valid), 32'h0);
      chk(mem_req_valid === 1'b0, "R1 no read in reset", 32'(mem_req_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
          "R1 after reset", {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

      // R9: low bits of the base value are ignored
      set_root(32'h0010_0FFF);

      walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0, 32'h0ABC_DABC, 1'b1,
           32'h0010_0004, 32'h0020_000C, 2, 1'b0, 0, "R4 read ok");
      walk(32'h0040_3ABC, 1'b1, 1'b0, 1'b0, 32'h0ABC_DABC, 1'b1,
           32'h0010_0004, 32'h0020_000C, 2, 1'b0, 0, "R3 write ok top not writable");
      walk(32'h0040_5123, 1'b0, 1'b0, 1'b0, 32'h0077_7123, 1'b0,
           32'h0010_0004, 32'h0020_0014, 2, 1'b0, 0, "R7 read of read-only");
      walk(32'h0040_5123, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0,
           32'h0010_0004, 32'h0020_0014, 2, 1'b0, 0, "R7 write to read-only");
      walk(32'h0080_0000, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0,
           32'h0010_0008, 32'h0, 1, 1'b0, 0, "R5 top invalid");
      walk(32'h0040_6FFF, 1'b0, 1'b1, 1'b1, 32'h0, 1'b0,
           32'h0010_0004, 32'h0020_0018, 2, 1'b0, 0, "R6 leaf invalid");

      // R10: backpressure and slower memory
      stall = 1'b1;
      lat   = 3;
      walk(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1,
           32'h0010_0FFC, 32'h0050_0FFC, 2, 1'b0, 0, "R10 stalled top index");
      walk(32'h0080_0123, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0,
           32'h0010_0008, 32'h0, 1, 1'b0, 0, "R5 stalled top invalid");
      stall = 1'b0;
      lat   = 0;

      // R9: context switch to base B
      set_root(32'h0030_0000);
      walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0, 32'h0123_4ABC, 1'b1,
           32'h0030_0004, 32'h0040_000C, 2, 1'b1, 32'h0010_0000, "R9 base B mid switch");
      walk(32'h0040_3ABC, 1'b0, 1'b0, 1'b0, 32'h0ABC_DABC, 1'b1,
           32'h0010_0004, 32'h0020_000C, 2, 1'b0, 0, "R9 base A after switch");

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 32'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule